// File: doc/BRIEF.md
# Pipelined Radix-2 Eight-Point FFT Engine

This block transforms one row of eight complex samples per clock into its eight-point discrete Fourier transform. It can run the forward transform or the inverse transform. It is meant to sit beside a row/column storage array inside a larger 64-point transform. The surrounding sequencer presents one row at a time on a wide parallel bus, raises `in_valid` for that row and selects the direction with `in_inverse`. Three cycles later the transformed row appears on the output bus together with `out_valid`.

Inside, the work is split across three registered stages, and each stage holds a different row. The first stage reorders the inputs into their even and odd halves and computes two four-point transforms. The second stage rotates the odd-half results by the eighth roots of unity. Two of these rotations use a pair of real multiplies with a shared pre-add. The quarter-turn rotation is a swap of the real and imaginary parts with a sign change, and the zero rotation passes through unchanged. The third stage performs the four final two-point butterflies. The wiring then places every bin at its natural position.

Each stage runs a small controller. The controller reports one of four states: LOAD (empty, waiting for a row), PROC (holding a freshly computed row), UNLOAD (its last row has just moved on), or HALT (the reset state). The three state codes are visible on the ports.

Top module: `fft8_pipe`

## Requirements
- R1: While `rst_n` is low, all three state outputs read 2'b11 (HALT) and `out_valid` is 0. The first rising edge after release moves every stage to 2'b00 (LOAD), and a row offered with `in_valid` at that edge is discarded.
- R2: Each stage follows these transitions. HALT→LOAD always. LOAD→PROC (2'b01) when a row arrives, otherwise it stays in LOAD. PROC→PROC when a row arrives, otherwise PROC→UNLOAD (2'b10). UNLOAD→PROC when a row arrives, otherwise UNLOAD→LOAD. For stage 1 a row arrives when `in_valid` is high. For stage 2 a row arrives when stage 1 is in PROC, and for stage 3 when stage 2 is in PROC.
- R3: A row accepted at a rising edge appears on `out_data` with `out_valid` high during the cycle that follows the third rising edge after it. Rows may be accepted on consecutive edges, one per cycle. `out_valid` is high exactly when stage 3 is in PROC.
- R4: Sample n of the input and bin k of the output occupy bits [36n+35:36n] of their bus. The real part is in the upper 18 bits [35:18] and the imaginary part in [17:0], each in 18-bit two's complement. Output bins are in natural order 0..7.
- R5: Forward mode computes X[k] = E[k] + W^k·O[k] and X[k+4] = E[k] − W^k·O[k] for k = 0..3. Here E and O are the four-point transforms of the even and odd samples, with W = e^(−j2π/8). The −j rotation inside them maps (re, im) to (im, −re).
- R6: Inverse mode uses conjugate twiddles in every stage. The rotation becomes +j, mapping (re, im) to (−im, re), and the multiplied twiddles become W^−1 and W^−3. No 1/8 scaling is applied.
- R7: For the odd-half bins 1 and 3, let a and b be the real and imaginary parts, and let q(v) = floor(v·92682 / 2^17) wrapped to 18 bits. The products are as follows. Forward bin 1 gives (q(a+b), q(b−a)). Forward bin 3 gives (q(b−a), q(−a−b)). Inverse bin 1 gives (q(a−b), q(a+b)). Inverse bin 3 gives (q(−a−b), q(a−b)).
- R8: Every addition, subtraction and negation wraps modulo 2^18, with no saturation and no internal scaling.
- R9: The direction bit is captured with each row and travels with it. Rows of different directions may follow each other on consecutive edges, and each is computed in its own direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A row is presented on `in_data` this cycle |
| in_inverse | input | 1 | 1 selects the inverse transform for the presented row |
| in_data | input | 288 | Eight complex input samples, sample n at [36n+35:36n] |
| out_valid | output | 1 | `out_data` holds a completed row |
| out_data | output | 288 | Eight complex output bins, bin k at [36k+35:36k] |
| s1_state | output | 2 | Stage 1 controller state code |
| s2_state | output | 2 | Stage 2 controller state code |
| s3_state | output | 2 | Stage 3 controller state code |

## Verification
The assertions check several properties on every cycle. They check the stage controller transitions and the HALT exit. They check that each stage can only hold a row when its upstream stage held one in the previous cycle. They also check a few cheap arithmetic invariants that cross a register: the first-stage sum of bins 0 and 2, the pass-through of the unrotated odd bin and the quarter-turn swap in both directions, and the third-stage butterfly sum. The exact values of the multiplied twiddles, the wraparound behaviour at full-scale inputs, the per-row direction when modes alternate, and the discarding of a row offered at the release edge can only be shown by the bench's scenarios. The bench compares them against a model built from the requirements.

// File: rtl/fft8_pkg.sv
package fft8_pkg;

    localparam int PART_W = 18;
    localparam int WORD_W = 2 * PART_W;
    localparam int NPTS   = 8;
    localparam int HALF   = NPTS / 2;
    localparam int FRAC_W = PART_W - 1;

    typedef struct packed {
        logic signed [PART_W-1:0] re;
        logic signed [PART_W-1:0] im;
    } cplx_t;

    typedef cplx_t [NPTS-1:0] row_t;
    typedef cplx_t [HALF-1:0] half_t;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'b00,
        ST_PROC   = 2'b01,
        ST_UNLOAD = 2'b10,
        ST_HALT   = 2'b11
    } stage_st_t;

    function automatic cplx_t c_add(input cplx_t a, input cplx_t b);
        cplx_t r;
        r.re = a.re + b.re;
        r.im = a.im + b.im;
        return r;
    endfunction

    function automatic cplx_t c_sub(input cplx_t a, input cplx_t b);
        cplx_t r;
        r.re = a.re - b.re;
        r.im = a.im - b.im;
        return r;
    endfunction

    // forward: multiply by -j ; inverse: multiply by +j
    function automatic cplx_t c_rotj(input cplx_t a, input logic inv);
        cplx_t r;
        if (inv) begin
            r.re = -a.im;
            r.im = a.re;
        end else begin
            r.re = a.im;
            r.im = -a.re;
        end
        return r;
    endfunction

endpackage

// File: rtl/fft8_stage_ctl.sv
module fft8_stage_ctl
    import fft8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arrive,
    output stage_st_t state,
    output logic      take,
    output logic      held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            unique case (state)
                ST_HALT:   state <= ST_LOAD;
                ST_LOAD:   state <= arrive ? ST_PROC : ST_LOAD;
                ST_PROC:   state <= arrive ? ST_PROC : ST_UNLOAD;
                ST_UNLOAD: state <= arrive ? ST_PROC : ST_LOAD;
            endcase
        end
    end

    always_comb begin
        take = arrive && (state != ST_HALT);
        held = (state == ST_PROC);
    end

    AST_HALT_EXIT: assert property (@(posedge clk) disable iff (!rst_n) // R1
        (state == ST_HALT) |=> (state == ST_LOAD));
    AST_ARRIVE_PROC: assert property (@(posedge clk) disable iff (!rst_n) // R2
        (arrive && state != ST_HALT) |=> (state == ST_PROC));
    AST_DRAIN_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n) // R2
        (state == ST_PROC && !arrive) |=> (state == ST_UNLOAD));
    AST_UNLOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) // R2
        (state == ST_UNLOAD && !arrive) |=> (state == ST_LOAD));

endmodule

// File: rtl/fft8_bfly4_stage.sv
module fft8_bfly4_stage
    import fft8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      in_inv,
    input  row_t      in_row,
    output stage_st_t state,
    output logic      out_valid,
    output logic      out_inv,
    output row_t      out_row
);

    logic take;
    row_t calc;

    fft8_stage_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .arrive (in_valid),
        .state  (state),
        .take   (take),
        .held   (out_valid)
    );

    // g = 0: even samples 0,2,4,6 -> lanes 0..3 ; g = 1: odd samples -> lanes 4..7
    for (genvar g = 0; g < 2; g++) begin : g_grp
        cplx_t s0, d0, s1, d1, rot;
        half_t grp;
        always_comb begin
            s0  = c_add(in_row[g],     in_row[g + 4]);
            d0  = c_sub(in_row[g],     in_row[g + 4]);
            s1  = c_add(in_row[g + 2], in_row[g + 6]);
            d1  = c_sub(in_row[g + 2], in_row[g + 6]);
            rot = c_rotj(d1, in_inv);
            grp[0] = c_add(s0, s1);
            grp[1] = c_add(d0, rot);
            grp[2] = c_sub(s0, s1);
            grp[3] = c_sub(d0, rot);
        end
        assign calc[HALF*g +: HALF] = grp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_row <= '0;
            out_inv <= 1'b0;
        end else if (take) begin
            out_row <= calc;
            out_inv <= in_inv;
        end
    end

    AST_S1_EVEN_SUM: assert property (@(posedge clk) disable iff (!rst_n) // R5
        out_valid |-> (PART_W'(out_row[0].re + out_row[2].re) ==
                       $past(PART_W'(in_row[0].re + in_row[4].re + in_row[0].re + in_row[4].re))));

endmodule

// File: rtl/fft8_twiddle_stage.sv
module fft8_twiddle_stage
    import fft8_pkg::*;
#(
    parameter logic signed [PART_W-1:0] COS_Q = 18'sd92682
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      in_inv,
    input  row_t      in_row,
    output stage_st_t state,
    output logic      out_valid,
    output row_t      out_row
);

    localparam int OPW = PART_W + 2;

    logic take;
    row_t calc;
    cplx_t [1:0] tw;

    fft8_stage_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .arrive (in_valid),
        .state  (state),
        .take   (take),
        .held   (out_valid)
    );

    function automatic logic signed [PART_W-1:0] scale(input logic signed [OPW-1:0] op);
        logic signed [OPW+PART_W-1:0] p;
        p = op * COS_Q;
        return p[FRAC_W +: PART_W];
    endfunction

    // g = 0 rotates odd bin 1, g = 1 rotates odd bin 3
    for (genvar g = 0; g < 2; g++) begin : g_mul
        localparam bit IS3 = (g == 1);
        logic signed [OPW-1:0] a, b, op_re, op_im;
        cplx_t res;
        always_comb begin
            a = in_row[HALF + 2*g + 1].re;
            b = in_row[HALF + 2*g + 1].im;
            unique case ({IS3, in_inv})
                2'b00: begin op_re = a + b;  op_im = b - a;  end
                2'b01: begin op_re = a - b;  op_im = a + b;  end
                2'b10: begin op_re = b - a;  op_im = -a - b; end
                2'b11: begin op_re = -a - b; op_im = a - b;  end
            endcase
            res.re = scale(op_re);
            res.im = scale(op_im);
        end
        assign tw[g] = res;
    end

    always_comb begin
        calc[HALF-1:0] = in_row[HALF-1:0];
        calc[HALF]     = in_row[HALF];
        calc[HALF+1]   = tw[0];
        calc[HALF+2]   = c_rotj(in_row[HALF+2], in_inv);
        calc[HALF+3]   = tw[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_row <= '0;
        end else if (take) begin
            out_row <= calc;
        end
    end

    AST_W0_PASS: assert property (@(posedge clk) disable iff (!rst_n) // R5
        out_valid |-> (out_row[HALF] == $past(in_row[HALF])));
    AST_W2_SWAP: assert property (@(posedge clk) disable iff (!rst_n) // R6
        out_valid |-> (out_row[HALF+2].re ==
                       ($past(in_inv) ? PART_W'(-$past(in_row[HALF+2].im)) : $past(in_row[HALF+2].im))));

endmodule

// File: rtl/fft8_bfly2_stage.sv
module fft8_bfly2_stage
    import fft8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  row_t      in_row,
    output stage_st_t state,
    output logic      out_valid,
    output row_t      out_row
);

    logic take;
    row_t calc;

    fft8_stage_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .arrive (in_valid),
        .state  (state),
        .take   (take),
        .held   (out_valid)
    );

    for (genvar k = 0; k < HALF; k++) begin : g_bf
        assign calc[k]        = c_add(in_row[k], in_row[k + HALF]);
        assign calc[k + HALF] = c_sub(in_row[k], in_row[k + HALF]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_row <= '0;
        end else if (take) begin
            out_row <= calc;
        end
    end

    AST_BFLY_SUM: assert property (@(posedge clk) disable iff (!rst_n) // R8
        out_valid |-> (PART_W'(out_row[0].re + out_row[HALF].re) ==
                       $past(PART_W'(in_row[0].re + in_row[0].re))));

endmodule

// File: rtl/fft8_pipe.sv
module fft8_pipe
    import fft8_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_inverse,
    input  logic [NPTS*WORD_W-1:0]   in_data,
    output logic                     out_valid,
    output logic [NPTS*WORD_W-1:0]   out_data,
    output logic [1:0]               s1_state,
    output logic [1:0]               s2_state,
    output logic [1:0]               s3_state
);

    row_t      in_row, r1, r2, r3;
    stage_st_t st1, st2, st3;
    logic      v1, v2, inv1;

    assign in_row = row_t'(in_data);

    fft8_bfly4_stage u_s1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_inv    (in_inverse),
        .in_row    (in_row),
        .state     (st1),
        .out_valid (v1),
        .out_inv   (inv1),
        .out_row   (r1)
    );

    fft8_twiddle_stage u_s2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (v1),
        .in_inv    (inv1),
        .in_row    (r1),
        .state     (st2),
        .out_valid (v2),
        .out_row   (r2)
    );

    fft8_bfly2_stage u_s3 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (v2),
        .in_row    (r2),
        .state     (st3),
        .out_valid (out_valid),
        .out_row   (r3)
    );

    assign out_data = r3;
    assign s1_state = st1;
    assign s2_state = st2;
    assign s3_state = st3;

    AST_S2_FOLLOWS_S1: assert property (@(posedge clk) disable iff (!rst_n) // R3
        (st2 == ST_PROC) |-> ($past(st1) == ST_PROC));
    AST_S3_FOLLOWS_S2: assert property (@(posedge clk) disable iff (!rst_n) // R3
        (st3 == ST_PROC) |-> ($past(st2) == ST_PROC));

endmodule

// File: tb/tb_fft8_pipe.sv
module tb_fft8_pipe;

    localparam int PW = 18;
    localparam int WW = 36;
    localparam int NP = 8;
    localparam int RW = NP * WW;
    localparam logic [1:0] M_LOAD = 2'b00, M_PROC = 2'b01, M_UNLOAD = 2'b10, M_HALT = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_inverse = 1'b0;
    logic [RW-1:0] in_data = '0;
    logic out_valid;
    logic [RW-1:0] out_data;
    logic [1:0] s1_state, s2_state, s3_state;

    fft8_pipe dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inverse(in_inverse),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .s1_state(s1_state), .s2_state(s2_state), .s3_state(s3_state)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic          mv [3];
    logic [RW-1:0] md [3];
    string         mt [3];
    logic [1:0]    ms [3];

    function automatic int w18(input longint v);
        logic [PW-1:0] t;
        t = v[PW-1:0];
        return int'($signed(t));
    endfunction

    function automatic int q(input longint v);
        longint p;
        p = (v * 64'sd92682) >>> 17;
        return w18(p);
    endfunction

    function automatic logic [1:0] nxt(input logic [1:0] s, input logic arr);
        case (s)
            M_HALT:   return M_LOAD;
            M_LOAD:   return arr ? M_PROC : M_LOAD;
            M_PROC:   return arr ? M_PROC : M_UNLOAD;
            default:  return arr ? M_PROC : M_LOAD;
        endcase
    endfunction

    function automatic logic [RW-1:0] mk_row(input int re [8], input int im [8]);
        logic [RW-1:0] r;
        for (int i = 0; i < NP; i++) begin
            r[WW*i+PW +: PW] = PW'(re[i]);
            r[WW*i +: PW]    = PW'(im[i]);
        end
        return r;
    endfunction

    // expected transform from R4..R8
    function automatic logic [RW-1:0] model_row(input logic [RW-1:0] d, input logic inv);
        int xr [8], xi [8], gr [8], gi [8], tr [4], ti [4], yr [8], yi [8];
        int a, b;
        for (int i = 0; i < NP; i++) begin
            xr[i] = int'($signed(d[WW*i+PW +: PW]));
            xi[i] = int'($signed(d[WW*i +: PW]));
        end
        for (int g = 0; g < 2; g++) begin
            int s0r = xr[g] + xr[g+4], s0i = xi[g] + xi[g+4];
            int d0r = xr[g] - xr[g+4], d0i = xi[g] - xi[g+4];
            int s1r = xr[g+2] + xr[g+6], s1i = xi[g+2] + xi[g+6];
            int d1r = xr[g+2] - xr[g+6], d1i = xi[g+2] - xi[g+6];
            int rr, ri;
            if (inv) begin rr = -d1i; ri = d1r; end
            else begin rr = d1i; ri = -d1r; end
            gr[4*g]   = w18(s0r + s1r); gi[4*g]   = w18(s0i + s1i);
            gr[4*g+1] = w18(d0r + rr);  gi[4*g+1] = w18(d0i + ri);
            gr[4*g+2] = w18(s0r - s1r); gi[4*g+2] = w18(s0i - s1i);
            gr[4*g+3] = w18(d0r - rr);  gi[4*g+3] = w18(d0i - ri);
        end
        tr[0] = gr[4]; ti[0] = gi[4];
        a = gr[5]; b = gi[5];
        if (inv) begin tr[1] = q(a - b); ti[1] = q(a + b); end
        else begin tr[1] = q(a + b); ti[1] = q(b - a); end
        if (inv) begin tr[2] = w18(-gi[6]); ti[2] = gr[6]; end
        else begin tr[2] = gi[6]; ti[2] = w18(-gr[6]); end
        a = gr[7]; b = gi[7];
        if (inv) begin tr[3] = q(-a - b); ti[3] = q(a - b); end
        else begin tr[3] = q(b - a); ti[3] = q(-a - b); end
        for (int k = 0; k < 4; k++) begin
            yr[k]   = w18(gr[k] + tr[k]); yi[k]   = w18(gi[k] + ti[k]);
            yr[k+4] = w18(gr[k] - tr[k]); yi[k+4] = w18(gi[k] - ti[k]);
        end
        return mk_row(yr, yi);
    endfunction

    function automatic logic [RW-1:0] rand_row(input bit wide);
        int re [8], im [8];
        for (int i = 0; i < NP; i++) begin
            if (wide) begin
                re[i] = w18(longint'($urandom));
                im[i] = w18(longint'($urandom));
            end else begin
                re[i] = int'($urandom_range(0, 1023)) - 512;
                im[i] = int'($urandom_range(0, 1023)) - 512;
            end
        end
        return mk_row(re, im);
    endfunction

    task automatic check_outputs();
        n_chk++;
        if (out_valid !== mv[2]) begin
            n_bad++;
            $display("FAIL R3 out_valid got %0b exp %0b", out_valid, mv[2]);
        end
        n_chk++;
        if ({s1_state, s2_state, s3_state} !== {ms[0], ms[1], ms[2]}) begin
            n_bad++;
            $display("FAIL R2 states got %b/%b/%b exp %b/%b/%b",
                     s1_state, s2_state, s3_state, ms[0], ms[1], ms[2]);
        end
        if (mv[2]) begin
            n_chk++;
            if (out_data !== md[2]) begin
                n_bad++;
                $display("FAIL %s out_data got %h exp %h", mt[2], out_data, md[2]);
            end
        end
    endtask

    task automatic cycle(input logic v, input logic inv, input logic [RW-1:0] d, input string tag);
        logic [1:0] n1, n2, n3;
        @(negedge clk);
        check_outputs();
        n3 = nxt(ms[2], ms[1] == M_PROC);
        n2 = nxt(ms[1], ms[0] == M_PROC);
        n1 = nxt(ms[0], v);
        mv[2] = mv[1]; md[2] = md[1]; mt[2] = mt[1];
        mv[1] = mv[0]; md[1] = md[0]; mt[1] = mt[0];
        mv[0] = v && (ms[0] != M_HALT);
        md[0] = model_row(d, inv);
        mt[0] = tag;
        ms[0] = n1; ms[1] = n2; ms[2] = n3;
        rst_n = 1'b1;
        in_valid = v;
        in_inverse = inv;
        in_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, '0, "idle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog expired got hang exp completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int re [8], im [8];
        logic [RW-1:0] row;
        void'($urandom(32'd715));
        for (int i = 0; i < 3; i++) begin
            mv[i] = 1'b0; md[i] = '0; mt[i] = "none"; ms[i] = M_HALT;
        end

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if ({s1_state, s2_state, s3_state, out_valid} !== {M_HALT, M_HALT, M_HALT, 1'b0}) begin
                n_bad++;
                $display("FAIL R1 reset got %b%b%b v=%b exp 111111 v=0",
                         s1_state, s2_state, s3_state, out_valid);
            end
        end
        // R1: row offered at the release edge is discarded
        row = rand_row(1'b0);
        cycle(1'b1, 1'b0, row, "R1");
        cycle(1'b0, 1'b0, '0, "idle");
        n_chk++;
        if (s1_state !== M_LOAD) begin
            n_bad++;
            $display("FAIL R1 s1_state after release got %b exp 00", s1_state);
        end
        idle(2);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 dropped row appeared got %b exp 0", out_valid);
        end

        // R5: impulse at sample 0, forward
        for (int i = 0; i < NP; i++) begin re[i] = 0; im[i] = 0; end
        re[0] = 100; im[0] = -50;
        cycle(1'b1, 1'b0, mk_row(re, im), "R5 impulse");
        idle(4);
        // R6: same impulse, inverse
        cycle(1'b1, 1'b1, mk_row(re, im), "R6 impulse inverse");
        idle(4);
        // R5: constant row
        for (int i = 0; i < NP; i++) begin re[i] = 7; im[i] = 3; end
        cycle(1'b1, 1'b0, mk_row(re, im), "R5 dc");
        idle(2);
        // R7: impulse at sample 1 exercises both multiplied twiddles
        for (int i = 0; i < NP; i++) begin re[i] = 0; im[i] = 0; end
        re[1] = 1000;
        cycle(1'b1, 1'b0, mk_row(re, im), "R7 fwd");
        cycle(1'b0, 1'b0, '0, "idle");
        cycle(1'b1, 1'b1, mk_row(re, im), "R7 inv");
        idle(1);
        // R4: imaginary-only sample at position 5
        for (int i = 0; i < NP; i++) begin re[i] = 0; im[i] = 0; end
        im[5] = 300;
        cycle(1'b1, 1'b0, mk_row(re, im), "R4 lane5 imag");
        idle(3);
        // R8: full-scale values wrap
        for (int i = 0; i < NP; i++) begin re[i] = 131071; im[i] = -131072; end
        cycle(1'b1, 1'b0, mk_row(re, im), "R8 fullscale");
        cycle(1'b1, 1'b1, mk_row(re, im), "R8 fullscale inv");
        idle(3);
        // R9: alternating directions back to back on the same data
        row = rand_row(1'b0);
        for (int i = 0; i < 6; i++) cycle(1'b1, i[0], row, "R9 alternate");
        idle(3);
        // R2/R3: random gaps, directions and ranges
        for (int i = 0; i < 300; i++) begin
            logic v;
            v = ($urandom_range(0, 3) != 0);
            cycle(v, 1'($urandom_range(0, 1)), rand_row($urandom_range(0, 4) == 0), "R5 random");
        end
        idle(5);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule